// File: doc/BRIEF.md
# DDR PSRAM Transaction Phase Engine

This block runs one complete access to an external double-data-rate pseudo-static RAM on an 8-line or 16-line bus. It accepts one request at a time: a 16-bit command, a 32-bit address, a lane-width select, a data length in clocks and, for writes, the data to send. It then walks through a fixed sequence of phases: chip-select setup, command, address, an optional latency (dummy) phase, data, and chip-select hold. After a short recovery gap it pulses done. Read data is returned in a flat buffer.

The pad side is modelled as two lane vectors per clock, one for the rising-edge beat and one for the falling-edge beat. Outside DDR output and input registers turn these into pin activity. Clock generation, pad timing, strobe calibration and error correction belong to other blocks.

The request side is a valid/ready stream with back-pressure. `req_ready` is high only while the engine is idle. A request is taken on the clock in which `req_valid` and `req_ready` are both high, and all request fields are sampled on that clock only. A requester may hold `req_valid` high for as long as it likes while `req_ready` is low. Nothing is taken until the engine is idle again.

Top module: `psram_phase_engine`

## Requirements
- R1: Out of reset, `req_ready` is high, `cs_n` is high, and `ck_en`, `dq_oe`, `done` and `rd_data` are all zero. `req_ready` stays low from the clock after acceptance until the clock in which `done` is high.
- R2: For the CS_SETUP (default 4) clocks that follow acceptance, `cs_n` is low and `ck_en` is low.
- R3: The command takes one clock with `ck_en` and `dq_oe` high. The rising lanes [7:0] carry `req_cmd[15:8]`, the falling lanes [7:0] carry `req_cmd[7:0]`, and the upper lanes are zero. The command codes are 0x0000 (synchronous read), 0x8080 (synchronous write), 0x2020 (burst read), 0xA0A0 (burst write), 0x4040 (register read) and 0xC0C0 (register write). Bit 15 marks a write and bit 14 marks a register access.
- R4: The address takes two clocks on lanes [7:0], most significant byte first. The first clock sends bits 31:24 on the rise and 23:16 on the fall. The second clock sends 15:8 on the rise and 7:0 on the fall.
- R5: Latency length depends on the access:
  - A memory write (bit 15 = 1, bit 14 = 0) waits WR_DUMMY_BITS/2 clocks (8 bits, so 4 clocks).
  - Any read (bit 15 = 0) waits RD_DUMMY_BITS/2 clocks (18 bits, so 9 clocks).
  - A register write (bits 15 and 14 both set) has no latency phase.
  
  During latency `ck_en` is high and `dq_oe` is low.
- R6: A write drives `req_len`+1 data clocks with `dq_oe` high. Beat k is `req_wdata[k*W +: W]`, where beat 0 is the rising edge of the first data clock and beat 1 is its falling edge. W is 16 when `req_wide`=1, and 8 (on lanes [7:0], upper lanes zero) when `req_wide`=0.
- R7: A read uses the same beat numbering: the rising input of data clock j is stored as beat 2j and the falling input as beat 2j+1, at `rd_data[k*W +: W]`. `dq_oe` is low on read data clocks. `rd_data` is cleared at acceptance. Bits past the last beat stay zero, a write leaves it zero, and it does not change until the next acceptance.
- R8: After the last data clock, `cs_n` stays low with `ck_en` low for CS_HOLD (default 4) clocks, then goes high.
- R9: `cs_n` stays high for CS_GAP (default 3) clocks. Then `done` is high for exactly one clock, and `req_ready` rises in that same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine idle, request will be taken |
| req_cmd | input | 16 | Command word |
| req_addr | input | 32 | Byte address |
| req_wide | input | 1 | 1: 16-line data beats, 0: 8-line data beats |
| req_len | input | LEN_W (2) | Data clocks minus one |
| req_wdata | input | BUF_W (128) | Write data, beat 0 in the low bits |
| cs_n | output | 1 | Chip select, active low |
| ck_en | output | 1 | Enables the memory clock toggle |
| dq_oe | output | 1 | Output enable for the data lanes |
| dq_out_rise | output | LANE_W (16) | Lanes driven on the rising edge |
| dq_out_fall | output | LANE_W (16) | Lanes driven on the falling edge |
| dq_in_rise | input | LANE_W (16) | Lanes captured on the rising edge |
| dq_in_fall | input | LANE_W (16) | Lanes captured on the falling edge |
| done | output | 1 | One-clock end-of-transaction pulse |
| rd_data | output | BUF_W (128) | Read data, beat 0 in the low bits |

## Verification
The embedded properties rely on the following about the inputs:
- The request fields matter only on the accepting clock.
- The parameters CS_SETUP, CS_HOLD and CS_GAP are at least one.
- The input lanes are meaningful only on read data clocks.

On that basis, the properties check phase lengths, the single-clock `done` pulse and the quiet lanes during latency and reads. The stimulus meets these assumptions as follows:
- It presents a request only on a clock where it has seen `req_ready` high, and drops `req_valid` immediately after acceptance.
- It changes the input lanes only between clock edges.
- It gives them a value unique to each clock since chip select fell, so that a capture one clock early or late shows up as wrong data.

// File: rtl/psram_phase_pkg.sv
`timescale 1ns/1ps
package psram_phase_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETUP,
    PH_CMD,
    PH_ADDR,
    PH_DUMMY,
    PH_DATA,
    PH_HOLD,
    PH_GAP
  } phase_e;

  // bit 15 of the command word selects write, bit 14 selects register space
  function automatic logic cmd_is_write(input logic [15:0] cmd);
    return cmd[15];
  endfunction

  function automatic logic cmd_is_reg(input logic [15:0] cmd);
    return cmd[14];
  endfunction

endpackage

// File: rtl/psram_phase_seq.sv
`timescale 1ns/1ps
module psram_phase_seq
  import psram_phase_pkg::*;
#(
  parameter int CS_SETUP = 4,
  parameter int CS_HOLD  = 4,
  parameter int CS_GAP   = 3,
  parameter int DUMMY_W  = 4,
  parameter int LEN_W    = 2,
  parameter int STEP_W   = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [DUMMY_W-1:0] dummy_clks,
  input  logic [LEN_W-1:0]   len_m1,
  output phase_e             phase,
  output logic [STEP_W-1:0]  step,
  output logic               done
);

  logic [DUMMY_W-1:0] dummy_q;
  logic [LEN_W-1:0]   len_q;
  logic [STEP_W-1:0]  cur_len;
  phase_e             nxt;

  // length of the current phase in clocks and the phase that follows it
  always_comb begin
    cur_len = STEP_W'(1);
    nxt     = PH_IDLE;
    case (phase)
      PH_SETUP: begin cur_len = STEP_W'(CS_SETUP); nxt = PH_CMD; end
      PH_CMD:   begin cur_len = STEP_W'(1);        nxt = PH_ADDR; end
      PH_ADDR:  begin
        cur_len = STEP_W'(2);
        nxt     = (dummy_q == '0) ? PH_DATA : PH_DUMMY;
      end
      PH_DUMMY: begin cur_len = STEP_W'(dummy_q);         nxt = PH_DATA; end
      PH_DATA:  begin cur_len = STEP_W'(len_q) + 1'b1;    nxt = PH_HOLD; end
      PH_HOLD:  begin cur_len = STEP_W'(CS_HOLD);         nxt = PH_GAP;  end
      PH_GAP:   begin cur_len = STEP_W'(CS_GAP);          nxt = PH_IDLE; end
      default:  begin cur_len = STEP_W'(1);               nxt = PH_IDLE; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      step    <= '0;
      done    <= 1'b0;
      dummy_q <= '0;
      len_q   <= '0;
    end else begin
      done <= 1'b0;
      if (phase == PH_IDLE) begin
        if (start) begin
          phase   <= PH_SETUP;
          step    <= '0;
          dummy_q <= dummy_clks;
          len_q   <= len_m1;
        end
      end else if (step == cur_len - 1'b1) begin
        step  <= '0;
        phase <= nxt;
        if (phase == PH_GAP) done <= 1'b1;
      end else begin
        step <= step + 1'b1;
      end
    end
  end

  // R9: done is a single-clock pulse
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9: done lands in the idle clock right after the gap
  a_r9_done_after_gap: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (phase == PH_IDLE) && ($past(phase) == PH_GAP));

  // R2: the command phase is entered only after a full setup count
  a_r2_setup_full: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_CMD) |-> ($past(phase) == PH_SETUP) &&
                          ($past(step) == STEP_W'(CS_SETUP - 1)));

  // R8: the gap is entered only after a full hold count
  a_r8_hold_full: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_GAP && $past(phase) == PH_HOLD) |->
      ($past(step) == STEP_W'(CS_HOLD - 1)));

  // R5: latency runs for exactly the latched number of clocks
  a_r5_dummy_len: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_DATA && $past(phase) == PH_DUMMY) |->
      ($past(step) == STEP_W'(dummy_q) - 1'b1));

endmodule

// File: rtl/psram_tx_lanes.sv
`timescale 1ns/1ps
module psram_tx_lanes
  import psram_phase_pkg::*;
#(
  parameter int LANE_W = 16,
  parameter int BUF_W  = 128,
  parameter int STEP_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [BUF_W-1:0]  wdata,
  input  logic [15:0]       cmd_q,
  input  logic [31:0]       addr_q,
  input  logic              wide_q,
  input  logic              write_q,
  input  phase_e            phase,
  input  logic [STEP_W-1:0] step,
  output logic [LANE_W-1:0] rise,
  output logic [LANE_W-1:0] fall,
  output logic              oe
);

  localparam int NW = LANE_W / 2;

  logic [BUF_W-1:0] wbuf;

  // write data drains from the low end, one clock's worth of beats at a time
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wbuf <= '0;
    end else if (start) begin
      wbuf <= wdata;
    end else if (phase == PH_DATA && write_q) begin
      wbuf <= wide_q ? (wbuf >> (2 * LANE_W)) : (wbuf >> LANE_W);
    end
  end

  always_comb begin
    rise = '0;
    fall = '0;
    oe   = 1'b0;
    case (phase)
      PH_CMD: begin
        rise = LANE_W'(cmd_q[15:8]);
        fall = LANE_W'(cmd_q[7:0]);
        oe   = 1'b1;
      end
      PH_ADDR: begin
        oe = 1'b1;
        if (step == '0) begin
          rise = LANE_W'(addr_q[31:24]);
          fall = LANE_W'(addr_q[23:16]);
        end else begin
          rise = LANE_W'(addr_q[15:8]);
          fall = LANE_W'(addr_q[7:0]);
        end
      end
      PH_DATA: begin
        if (write_q) begin
          oe = 1'b1;
          if (wide_q) begin
            rise = wbuf[LANE_W-1:0];
            fall = wbuf[2*LANE_W-1:LANE_W];
          end else begin
            rise = LANE_W'(wbuf[NW-1:0]);
            fall = LANE_W'(wbuf[LANE_W-1:NW]);
          end
        end
      end
      default: ;
    endcase
  end

  // R6: narrow beats leave the upper lanes at zero
  a_r6_narrow_upper: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_DATA && oe && !wide_q) |->
      (rise[LANE_W-1:NW] == '0) && (fall[LANE_W-1:NW] == '0));

  // R5: the lanes are released during latency
  a_r5_quiet_dummy: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_DUMMY) |-> !oe);

  // R7: the lanes are released while read data comes back
  a_r7_read_released: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_DATA && !write_q) |-> !oe);

endmodule

// File: rtl/psram_rx_capture.sv
`timescale 1ns/1ps
module psram_rx_capture #(
  parameter int LANE_W = 16,
  parameter int BUF_W  = 128,
  parameter int STEP_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              capture,
  input  logic              wide_q,
  input  logic [STEP_W-1:0] step,
  input  logic [LANE_W-1:0] in_rise,
  input  logic [LANE_W-1:0] in_fall,
  output logic [BUF_W-1:0]  rd_data
);

  localparam int NW    = LANE_W / 2;
  localparam int IDX_W = $clog2(BUF_W);

  logic [IDX_W-1:0] base_w;
  logic [IDX_W-1:0] base_n;

  assign base_w = IDX_W'(IDX_W'(step) * IDX_W'(2 * LANE_W));
  assign base_n = IDX_W'(IDX_W'(step) * IDX_W'(LANE_W));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data <= '0;
    end else if (start) begin
      rd_data <= '0;
    end else if (capture) begin
      if (wide_q) begin
        rd_data[base_w +: LANE_W]          <= in_rise;
        rd_data[base_w + LANE_W +: LANE_W] <= in_fall;
      end else begin
        rd_data[base_n +: NW]      <= in_rise[NW-1:0];
        rd_data[base_n + NW +: NW] <= in_fall[NW-1:0];
      end
    end
  end

  // R7: the buffer only moves on acceptance or on a read data clock
  a_r7_buffer_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (!capture && !start) |=> $stable(rd_data));

endmodule

// File: rtl/psram_phase_engine.sv
`timescale 1ns/1ps
module psram_phase_engine
  import psram_phase_pkg::*;
#(
  parameter int LANE_W        = 16,
  parameter int MAX_DATA_CLKS = 4,
  parameter int CS_SETUP      = 4,
  parameter int CS_HOLD       = 4,
  parameter int CS_GAP        = 3,
  parameter int RD_DUMMY_BITS = 18,
  parameter int WR_DUMMY_BITS = 8,
  localparam int LEN_W        = $clog2(MAX_DATA_CLKS),
  localparam int BUF_W        = MAX_DATA_CLKS * 2 * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [15:0]       req_cmd,
  input  logic [31:0]       req_addr,
  input  logic              req_wide,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [BUF_W-1:0]  req_wdata,
  output logic              cs_n,
  output logic              ck_en,
  output logic              dq_oe,
  output logic [LANE_W-1:0] dq_out_rise,
  output logic [LANE_W-1:0] dq_out_fall,
  input  logic [LANE_W-1:0] dq_in_rise,
  input  logic [LANE_W-1:0] dq_in_fall,
  output logic              done,
  output logic [BUF_W-1:0]  rd_data
);

  // latency is given in DDR beats; two beats pass per clock
  localparam int RD_DUMMY_CLKS = RD_DUMMY_BITS / 2;
  localparam int WR_DUMMY_CLKS = WR_DUMMY_BITS / 2;
  localparam int DUMMY_MAX     = (RD_DUMMY_CLKS > WR_DUMMY_CLKS) ? RD_DUMMY_CLKS : WR_DUMMY_CLKS;
  localparam int DUMMY_W       = $clog2(DUMMY_MAX + 1);
  localparam int STEP_W        = $clog2(MAX_DATA_CLKS + DUMMY_MAX + CS_SETUP + CS_HOLD + CS_GAP + 4);

  phase_e             phase;
  logic [STEP_W-1:0]  step;
  logic               start;
  logic [DUMMY_W-1:0] dummy_clks;
  logic [15:0]        cmd_q;
  logic [31:0]        addr_q;
  logic               wide_q;
  logic               write_q;

  assign req_ready = (phase == PH_IDLE);
  assign start     = req_valid && req_ready;
  assign cs_n      = (phase == PH_IDLE) || (phase == PH_GAP);
  assign ck_en     = (phase == PH_CMD) || (phase == PH_ADDR) ||
                     (phase == PH_DUMMY) || (phase == PH_DATA);

  always_comb begin
    if (cmd_is_write(req_cmd))
      dummy_clks = cmd_is_reg(req_cmd) ? '0 : DUMMY_W'(WR_DUMMY_CLKS);
    else
      dummy_clks = DUMMY_W'(RD_DUMMY_CLKS);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q   <= '0;
      addr_q  <= '0;
      wide_q  <= 1'b0;
      write_q <= 1'b0;
    end else if (start) begin
      cmd_q   <= req_cmd;
      addr_q  <= req_addr;
      wide_q  <= req_wide;
      write_q <= cmd_is_write(req_cmd);
    end
  end

  psram_phase_seq #(
    .CS_SETUP (CS_SETUP),
    .CS_HOLD  (CS_HOLD),
    .CS_GAP   (CS_GAP),
    .DUMMY_W  (DUMMY_W),
    .LEN_W    (LEN_W),
    .STEP_W   (STEP_W)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .dummy_clks (dummy_clks),
    .len_m1     (req_len),
    .phase      (phase),
    .step       (step),
    .done       (done)
  );

  psram_tx_lanes #(
    .LANE_W (LANE_W),
    .BUF_W  (BUF_W),
    .STEP_W (STEP_W)
  ) u_tx (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .wdata   (req_wdata),
    .cmd_q   (cmd_q),
    .addr_q  (addr_q),
    .wide_q  (wide_q),
    .write_q (write_q),
    .phase   (phase),
    .step    (step),
    .rise    (dq_out_rise),
    .fall    (dq_out_fall),
    .oe      (dq_oe)
  );

  psram_rx_capture #(
    .LANE_W (LANE_W),
    .BUF_W  (BUF_W),
    .STEP_W (STEP_W)
  ) u_rx (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .capture ((phase == PH_DATA) && !write_q),
    .wide_q  (wide_q),
    .step    (step),
    .in_rise (dq_in_rise),
    .in_fall (dq_in_fall),
    .rd_data (rd_data)
  );

  // R1: a ready engine has chip select and clock parked
  a_r1_ready_parked: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> cs_n && !ck_en && !dq_oe);

  // R8: no clock and no drive while chip select is high
  a_r8_deselected_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !ck_en && !dq_oe);

  // R2: chip select falls with the clock still stopped
  a_r2_cs_fall_no_clock: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> !ck_en);

endmodule

// File: tb/sim_psram_phase_engine.sv
`timescale 1ns/1ps
module sim_psram_phase_engine;

  localparam int LANE_W = 16;
  localparam int BUF_W  = 128;
  localparam int NREC   = 80;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [15:0]       req_cmd = '0;
  logic [31:0]       req_addr = '0;
  logic              req_wide = 1'b0;
  logic [1:0]        req_len = '0;
  logic [BUF_W-1:0]  req_wdata = '0;
  logic              cs_n, ck_en, dq_oe, done;
  logic [LANE_W-1:0] dq_out_rise, dq_out_fall;
  logic [LANE_W-1:0] dq_in_rise = '0;
  logic [LANE_W-1:0] dq_in_fall = '0;
  logic [BUF_W-1:0]  rd_data;

  int n_chk = 0;
  int n_fail = 0;

  logic              rec_cs  [NREC];
  logic              rec_ck  [NREC];
  logic              rec_oe  [NREC];
  logic              rec_rdy [NREC];
  logic [LANE_W-1:0] rec_r   [NREC];
  logic [LANE_W-1:0] rec_f   [NREC];
  int                done_c;

  always #2 clk = ~clk;

  psram_phase_engine u0 (
    .clk (clk), .rst_n (rst_n),
    .req_valid (req_valid), .req_ready (req_ready),
    .req_cmd (req_cmd), .req_addr (req_addr), .req_wide (req_wide),
    .req_len (req_len), .req_wdata (req_wdata),
    .cs_n (cs_n), .ck_en (ck_en), .dq_oe (dq_oe),
    .dq_out_rise (dq_out_rise), .dq_out_fall (dq_out_fall),
    .dq_in_rise (dq_in_rise), .dq_in_fall (dq_in_fall),
    .done (done), .rd_data (rd_data)
  );

  task automatic chk(input string rq, input logic [BUF_W-1:0] act, input logic [BUF_W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // input lanes carry a value unique to each clock since chip select fell
  function automatic logic [LANE_W-1:0] in_val(input int c, input int edge_sel);
    return 16'hC000 | 16'(2 * c + edge_sel);
  endfunction

  // issue one request and record every clock until done
  task automatic txn(input logic [15:0] cmd, input logic [31:0] addr, input logic wide,
                     input int nclk, input logic [BUF_W-1:0] wd);
    @(negedge clk);
    req_cmd = cmd; req_addr = addr; req_wide = wide;
    req_len = 2'(nclk - 1); req_wdata = wd; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    req_cmd = 16'hFFFF; req_addr = 32'hFFFF_FFFF; req_wdata = '1;
    done_c = -1;
    for (int c = 0; c < NREC; c++) begin
      rec_cs[c] = cs_n; rec_ck[c] = ck_en; rec_oe[c] = dq_oe; rec_rdy[c] = req_ready;
      rec_r[c] = dq_out_rise; rec_f[c] = dq_out_fall;
      dq_in_rise = in_val(c, 0);
      dq_in_fall = in_val(c, 1);
      if (done) begin
        done_c = c;
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic check_txn(input logic [15:0] cmd, input logic [31:0] addr, input logic wide,
                           input int nclk, input logic [BUF_W-1:0] wd, input string nm);
    int d, t0, ok, bw;
    logic [BUF_W-1:0] exp_rd;
    d  = (cmd[15] && cmd[14]) ? 0 : (cmd[15] ? 4 : 9);
    t0 = 7 + d;
    bw = wide ? 16 : 8;
    // R1: not ready while busy
    ok = 1;
    for (int c = 0; c < t0 + nclk + 7; c++) if (rec_rdy[c] !== 1'b0) ok = 0;
    chk({"R1 busy not ready ", nm}, ok, 1);
    // R2: setup with clock stopped
    ok = 1;
    for (int c = 0; c < 4; c++) if (rec_cs[c] !== 1'b0 || rec_ck[c] !== 1'b0) ok = 0;
    chk({"R2 cs setup ", nm}, ok, 1);
    // R3: command bytes
    chk({"R3 command ", nm}, {rec_oe[4], rec_ck[4], rec_r[4], rec_f[4]},
        {1'b1, 1'b1, 16'(cmd[15:8]), 16'(cmd[7:0])});
    // R4: address MSB first
    chk({"R4 address ", nm}, {rec_r[5], rec_f[5], rec_r[6], rec_f[6], rec_oe[5], rec_oe[6]},
        {16'(addr[31:24]), 16'(addr[23:16]), 16'(addr[15:8]), 16'(addr[7:0]), 2'b11});
    // R5: latency length and quiet lanes
    ok = 1;
    for (int c = 7; c < t0; c++) if (rec_cs[c] !== 1'b0 || rec_ck[c] !== 1'b1 || rec_oe[c] !== 1'b0) ok = 0;
    if (cmd[15] && rec_oe[t0] !== 1'b1) ok = 0;
    if (cmd[15] && t0 > 7 && rec_oe[t0-1] !== 1'b0) ok = 0;
    chk({"R5 latency ", nm}, ok, 1);
    if (cmd[15]) begin
      // R6: write beats
      for (int j = 0; j < nclk; j++) begin
        chk({"R6 write beats ", nm},
            {rec_oe[t0+j], rec_r[t0+j], rec_f[t0+j]},
            {1'b1, wide ? wd[(2*j)*16 +: 16] : 16'(wd[(2*j)*8 +: 8]),
                   wide ? wd[(2*j+1)*16 +: 16] : 16'(wd[(2*j+1)*8 +: 8])});
      end
      chk({"R7 write leaves read buffer clear ", nm}, rd_data, '0);
    end else begin
      // R7: read capture
      exp_rd = '0;
      ok = 1;
      for (int j = 0; j < nclk; j++) begin
        if (rec_oe[t0+j] !== 1'b0) ok = 0;
        if (wide) begin
          exp_rd[(2*j)*16 +: 16]   = in_val(t0 + j, 0);
          exp_rd[(2*j+1)*16 +: 16] = in_val(t0 + j, 1);
        end else begin
          exp_rd[(2*j)*8 +: 8]   = 8'(in_val(t0 + j, 0));
          exp_rd[(2*j+1)*8 +: 8] = 8'(in_val(t0 + j, 1));
        end
      end
      chk({"R7 read lanes released ", nm}, ok, 1);
      chk({"R7 read data ", nm}, rd_data, exp_rd);
    end
    // R8: hold with clock stopped, then release
    ok = 1;
    for (int c = t0 + nclk; c < t0 + nclk + 4; c++) if (rec_cs[c] !== 1'b0 || rec_ck[c] !== 1'b0) ok = 0;
    if (rec_cs[t0+nclk+4] !== 1'b1) ok = 0;
    chk({"R8 cs hold ", nm}, ok, 1);
    // R9: gap then done with ready
    ok = 1;
    for (int c = t0 + nclk + 4; c < t0 + nclk + 7; c++) if (rec_cs[c] !== 1'b1 || rec_rdy[c] !== 1'b0) ok = 0;
    chk({"R9 gap ", nm}, ok, 1);
    chk({"R9 done clock ", nm}, done_c, t0 + nclk + 7);
    chk({"R9 ready with done ", nm}, req_ready, 1);
    @(negedge clk);
    chk({"R9 done one clock ", nm}, done, 0);
  endtask

  task automatic t_reset;
    chk("R1 reset cs_n", cs_n, 1);
    chk("R1 reset ready", req_ready, 1);
    chk("R1 reset quiet", {ck_en, dq_oe, done}, 0);
    chk("R1 reset rd_data", rd_data, '0);
  endtask

  task automatic t_sync_read_wide;
    txn(16'h0000, 32'h1234_5678, 1'b1, 4, '0);
    check_txn(16'h0000, 32'h1234_5678, 1'b1, 4, '0, "sync read x16");
  endtask

  task automatic t_sync_write_wide;
    logic [BUF_W-1:0] wd = 128'h0F0E_0D0C_0B0A_0908_0706_0504_0302_0100;
    txn(16'h8080, 32'hA5C3_0F81, 1'b1, 2, wd);
    check_txn(16'h8080, 32'hA5C3_0F81, 1'b1, 2, wd, "sync write x16");
  endtask

  task automatic t_burst_write_narrow;
    logic [BUF_W-1:0] wd = 128'hDEAD_BEEF_CAFE_F00D_1357_9BDF_2468_ACE0;
    txn(16'hA0A0, 32'h0000_0040, 1'b0, 3, wd);
    check_txn(16'hA0A0, 32'h0000_0040, 1'b0, 3, wd, "burst write x8");
  endtask

  task automatic t_reg_write;
    logic [BUF_W-1:0] wd = 128'h0000_0000_0000_0000_0000_0000_0000_3C2D;
    txn(16'hC0C0, 32'h0000_0004, 1'b0, 1, wd);
    check_txn(16'hC0C0, 32'h0000_0004, 1'b0, 1, wd, "register write no latency");
  endtask

  task automatic t_reg_read;
    txn(16'h4040, 32'h0000_0008, 1'b0, 1, '0);
    check_txn(16'h4040, 32'h0000_0008, 1'b0, 1, '0, "register read");
  endtask

  task automatic t_burst_read_narrow;
    txn(16'h2020, 32'hFEDC_BA98, 1'b0, 4, '0);
    check_txn(16'h2020, 32'hFEDC_BA98, 1'b0, 4, '0, "burst read x8");
  endtask

  initial begin
    #(4 * 60000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog R9 transaction never completed");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_sync_read_wide;
    t_sync_write_wide;
    t_burst_write_narrow;
    t_reg_write;
    t_reg_read;
    t_burst_read_narrow;
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule